// File: doc/BRIEF.md
# Effective Address and Stack Unit

This block produces the memory addresses for a small 32-bit load/store datapath on a little-endian machine. A combinational path forms an operand address from an optional base register value, an optional index register value scaled by 1, 2 or 4, and an optional sign-extended displacement. It then converts the low address bits and the access size into byte-lane enables for a 32-bit memory port, and it raises a flag when the access would cross a word boundary.

A registered path holds the stack pointer and sequences push and pop through a small state machine. The states are `ST_IDLE`, `ST_PUSH_WR`, `ST_POP_RD` and `ST_FAULT`. From `ST_IDLE` there are four transitions. A lone push lowers the pointer by the operand size and enters `ST_PUSH_WR`, where the write goes out at the new pointer. A lone pop enters `ST_POP_RD`, where the read goes out at the unchanged pointer. Push and pop together enter `ST_FAULT`. With no request the machine stays in `ST_IDLE`. Each of `ST_PUSH_WR`, `ST_POP_RD` and `ST_FAULT` returns to `ST_IDLE` after one cycle. On leaving `ST_POP_RD` the pointer is raised by the operand size.

Top module: `addr_stack_unit`

## Requirements
- R1: `am_mode_i` selects the address form: 0 gives displacement only, 1 gives base only, 2 gives base plus displacement, 3 gives scaled index plus displacement, and 4 gives base plus scaled index plus displacement. Codes 5 to 7 give address 0.
- R2: `am_scale_i` multiplies the index: code 0 gives ×1, code 1 gives ×2, and codes 2 and 3 give ×4.
- R3: `am_dsz_i` sizes the displacement. Code 0 means no displacement (zero). Code 1 means `am_disp_i[7:0]` sign-extended. Code 2 means `am_disp_i[15:0]` sign-extended. Code 3 means all 32 bits. Every sum wraps modulo 2^32.
- R4: Byte enable bit k selects data bits 8k+7:8k (little endian). `am_acc_i` sets the access width: code 0 is 1 byte, code 1 is 2 bytes, and codes 2 and 3 are 4 bytes. For an access that fits, the enables cover that many consecutive lanes starting at lane `address[1:0]`.
- R5: An access whose first lane plus its width exceeds 4 sets the misaligned output and drives all enables to 0.
- R6: A synchronous reset loads the stack pointer with `SP_RESET` (default 0x1000), returns the machine to `ST_IDLE` and clears every stack strobe.
- R7: A push accepted in `ST_IDLE` lowers the pointer by 2 (`stk_sz4_i`=0) or 4 (`stk_sz4_i`=1). In the next cycle `stk_wr_o` is high for exactly one cycle, and `stk_addr_o` carries the new pointer.
- R8: A pop accepted in `ST_IDLE` raises `stk_rd_o` for one cycle in the next cycle, with `stk_addr_o` equal to the unchanged pointer. The pointer then rises by the operand size one cycle later.
- R9: Push and pop asserted together in `ST_IDLE` raise `stk_err_o` for one cycle and leave the pointer unchanged.
- R10: Requests that arrive while `stk_busy_o` is high are ignored. At most one of write, read and error is high in any cycle.
- R11: During a stack strobe, `stk_be_o` and `stk_mis_o` follow R4 and R5 for the stack address, with a width of 2 or 4 bytes. Outside a strobe both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| am_mode_i | input | 3 | Address form select |
| am_base_i | input | 32 | Base register value |
| am_index_i | input | 32 | Index register value |
| am_scale_i | input | 2 | Index scale code |
| am_disp_i | input | 32 | Displacement field |
| am_dsz_i | input | 2 | Displacement size code |
| am_acc_i | input | 2 | Access width code |
| am_addr_o | output | 32 | Effective address |
| am_be_o | output | 4 | Byte enables for the effective address |
| am_mis_o | output | 1 | Effective access crosses a word |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request |
| stk_sz4_i | input | 1 | Stack operand is 4 bytes (else 2) |
| sp_o | output | 32 | Stack pointer |
| stk_addr_o | output | 32 | Stack access address |
| stk_be_o | output | 4 | Stack byte enables |
| stk_mis_o | output | 1 | Stack access crosses a word |
| stk_wr_o | output | 1 | Stack write strobe |
| stk_rd_o | output | 1 | Stack read strobe |
| stk_err_o | output | 1 | Push/pop conflict pulse |
| stk_busy_o | output | 1 | Stack machine not idle |

## Verification
The bench targets displacements whose sign bit is set at 8 and 16 bits. A design that zero-extends them lands 256 or 65536 bytes too high. It also drives sums that wrap past 2^32, scale code 3, reserved mode codes, and accesses that start at lane 3 or at lane 1 with 4 bytes, where a wrong design would leak enables into a neighbouring word. On the stack side it checks the order of pointer change against strobe, the push and pop conflict, requests made while busy, and a 4-byte push at a pointer that is only 2-byte aligned. A unit with the order reversed would write above the stack top or read below it, and a unit that accepts requests while busy would move the pointer twice.

// File: rtl/asu_pkg.sv
package asu_pkg;
    typedef enum logic [2:0] {
        AM_DISP       = 3'd0,
        AM_BASE       = 3'd1,
        AM_BASE_DISP  = 3'd2,
        AM_INDEX_DISP = 3'd3,
        AM_FULL       = 3'd4
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PUSH_WR = 2'd1,
        ST_POP_RD  = 2'd2,
        ST_FAULT   = 2'd3
    } stk_state_e;

    localparam logic [1:0] ACC_B1 = 2'd0;
    localparam logic [1:0] ACC_B2 = 2'd1;
    localparam logic [1:0] ACC_B4 = 2'd2;
endpackage

// File: rtl/ea_calc.sv
module ea_calc
    import asu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [2:0]    mode_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] index_i,
    input  logic [1:0]    scale_i,
    input  logic [AW-1:0] disp_i,
    input  logic [1:0]    dsz_i,
    output logic [AW-1:0] ea_o
);
    logic [AW-1:0] disp_x;
    logic [AW-1:0] idx_s;

    always_comb begin
        unique case (dsz_i)
            2'd0:    disp_x = '0;
            2'd1:    disp_x = {{(AW-8){disp_i[7]}}, disp_i[7:0]};
            2'd2:    disp_x = {{(AW-16){disp_i[15]}}, disp_i[15:0]};
            default: disp_x = disp_i;
        endcase
    end

    always_comb begin
        unique case (scale_i)
            2'd0:    idx_s = index_i;
            2'd1:    idx_s = index_i << 1;
            default: idx_s = index_i << 2;
        endcase
    end

    always_comb begin
        unique case (mode_i)
            AM_DISP:       ea_o = disp_x;
            AM_BASE:       ea_o = base_i;
            AM_BASE_DISP:  ea_o = base_i + disp_x;
            AM_INDEX_DISP: ea_o = idx_s + disp_x;
            AM_FULL:       ea_o = base_i + idx_s + disp_x;
            default:       ea_o = '0;
        endcase
    end
endmodule

// File: rtl/lane_map.sv
module lane_map #(
    parameter int NBYTES = 4,
    localparam int OW    = $clog2(NBYTES)
) (
    input  logic [OW-1:0]     off_i,
    input  logic [1:0]        acc_i,
    input  logic              en_i,
    output logic [NBYTES-1:0] be_o,
    output logic              mis_o
);
    localparam int SW = OW + 2;

    logic [SW-1:0]       width;
    logic [SW-1:0]       last;
    logic [2*NBYTES-1:0] span;

    always_comb begin
        unique case (acc_i)
            2'd0:    width = SW'(1);
            2'd1:    width = SW'(2);
            default: width = SW'(4);
        endcase
        last  = SW'(off_i) + width;
        span  = ((2*NBYTES)'(1) << width) - (2*NBYTES)'(1);
        span  = span << off_i;
        mis_o = en_i && (last > SW'(NBYTES));
        be_o  = (en_i && !mis_o) ? span[NBYTES-1:0] : '0;
    end
endmodule

// File: rtl/stack_ctl.sv
module stack_ctl
    import asu_pkg::*;
#(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] SP_RESET = 32'h0000_1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          sz4_i,
    output logic [AW-1:0] sp_o,
    output logic [AW-1:0] addr_o,
    output logic [1:0]    acc_o,
    output logic          wr_o,
    output logic          rd_o,
    output logic          err_o,
    output logic          busy_o
);
    stk_state_e    state_q, state_d;
    logic [AW-1:0] sp_q, sp_d;
    logic          sz4_q, sz4_d;

    function automatic logic [AW-1:0] step(input logic four);
        return four ? AW'(4) : AW'(2);
    endfunction

    always_comb begin
        state_d = state_q;
        sp_d    = sp_q;
        sz4_d   = sz4_q;
        unique case (state_q)
            ST_IDLE: begin
                if (push_i && pop_i) begin
                    state_d = ST_FAULT;
                end else if (push_i) begin
                    state_d = ST_PUSH_WR;
                    sp_d    = sp_q - step(sz4_i);
                    sz4_d   = sz4_i;
                end else if (pop_i) begin
                    state_d = ST_POP_RD;
                    sz4_d   = sz4_i;
                end
            end
            ST_PUSH_WR: state_d = ST_IDLE;
            ST_POP_RD: begin
                state_d = ST_IDLE;
                sp_d    = sp_q + step(sz4_q);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sp_q    <= SP_RESET;
            sz4_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sp_q    <= sp_d;
            sz4_q   <= sz4_d;
        end
    end

    always_comb begin
        sp_o   = sp_q;
        addr_o = sp_q;
        acc_o  = sz4_q ? ACC_B4 : ACC_B2;
        wr_o   = (state_q == ST_PUSH_WR);
        rd_o   = (state_q == ST_POP_RD);
        err_o  = (state_q == ST_FAULT);
        busy_o = (state_q != ST_IDLE);
    end

    // R7
    push_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && push_i && !pop_i) |=>
            (wr_o && sp_q == $past(sp_q) - ($past(sz4_i) ? AW'(4) : AW'(2))));

    // R8
    pop_rise_chk: assert property (@(posedge clk) disable iff (rst)
        rd_o |=> (!rd_o && sp_q == $past(sp_q) + ($past(sz4_q) ? AW'(4) : AW'(2))));

    // R9
    conflict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && push_i && pop_i) |=> (err_o && $stable(sp_q)));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_o, rd_o, err_o}));

    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !busy_o);
endmodule

// File: rtl/addr_stack_unit.sv
module addr_stack_unit
    import asu_pkg::*;
#(
    parameter int          AW       = 32,
    parameter logic [31:0] SP_RESET = 32'h0000_1000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    am_mode_i,
    input  logic [AW-1:0] am_base_i,
    input  logic [AW-1:0] am_index_i,
    input  logic [1:0]    am_scale_i,
    input  logic [AW-1:0] am_disp_i,
    input  logic [1:0]    am_dsz_i,
    input  logic [1:0]    am_acc_i,
    output logic [AW-1:0] am_addr_o,
    output logic [3:0]    am_be_o,
    output logic          am_mis_o,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic          stk_sz4_i,
    output logic [AW-1:0] sp_o,
    output logic [AW-1:0] stk_addr_o,
    output logic [3:0]    stk_be_o,
    output logic          stk_mis_o,
    output logic          stk_wr_o,
    output logic          stk_rd_o,
    output logic          stk_err_o,
    output logic          stk_busy_o
);
    logic [1:0] stk_acc;

    ea_calc #(.AW(AW)) u_ea (
        .mode_i  (am_mode_i),
        .base_i  (am_base_i),
        .index_i (am_index_i),
        .scale_i (am_scale_i),
        .disp_i  (am_disp_i),
        .dsz_i   (am_dsz_i),
        .ea_o    (am_addr_o)
    );

    lane_map #(.NBYTES(4)) u_ea_lanes (
        .off_i (am_addr_o[1:0]),
        .acc_i (am_acc_i),
        .en_i  (1'b1),
        .be_o  (am_be_o),
        .mis_o (am_mis_o)
    );

    stack_ctl #(.AW(AW), .SP_RESET(AW'(SP_RESET))) u_stk (
        .clk    (clk),
        .rst    (rst),
        .push_i (push_i),
        .pop_i  (pop_i),
        .sz4_i  (stk_sz4_i),
        .sp_o   (sp_o),
        .addr_o (stk_addr_o),
        .acc_o  (stk_acc),
        .wr_o   (stk_wr_o),
        .rd_o   (stk_rd_o),
        .err_o  (stk_err_o),
        .busy_o (stk_busy_o)
    );

    lane_map #(.NBYTES(4)) u_stk_lanes (
        .off_i (stk_addr_o[1:0]),
        .acc_i (stk_acc),
        .en_i  (stk_wr_o | stk_rd_o),
        .be_o  (stk_be_o),
        .mis_o (stk_mis_o)
    );

    // R4
    ea_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        !am_mis_o |-> ($countones(am_be_o) != 0 && am_be_o[am_addr_o[1:0]]));

    // R11
    stk_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        ((stk_wr_o || stk_rd_o) && !stk_mis_o) |->
            ($countones(stk_be_o) == ((stk_acc == ACC_B4) ? 4 : 2)));

    // R11
    stk_idle_lanes_chk: assert property (@(posedge clk) disable iff (rst)
        !(stk_wr_o || stk_rd_o) |-> (stk_be_o == 4'b0 && !stk_mis_o));
endmodule

// File: tb/test_addr_stack_unit.sv
module test_addr_stack_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  am_mode_i = '0;
    logic [31:0] am_base_i = '0, am_index_i = '0, am_disp_i = '0;
    logic [1:0]  am_scale_i = '0, am_dsz_i = '0, am_acc_i = '0;
    logic [31:0] am_addr_o;
    logic [3:0]  am_be_o;
    logic        am_mis_o;
    logic        push_i = 1'b0, pop_i = 1'b0, stk_sz4_i = 1'b0;
    logic [31:0] sp_o, stk_addr_o;
    logic [3:0]  stk_be_o;
    logic        stk_mis_o, stk_wr_o, stk_rd_o, stk_err_o, stk_busy_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [31:0] exp_sp;

    always #10 clk = ~clk;

    addr_stack_unit i_addr_stack_unit (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] f_ea(input logic [2:0] m, input logic [31:0] b, input logic [31:0] x,
                                         input logic [1:0] sc, input logic [31:0] d, input logic [1:0] dz);
        logic [31:0] dv, xv;
        case (dz)
            2'd0: dv = 32'd0;
            2'd1: dv = 32'($signed(d[7:0]));
            2'd2: dv = 32'($signed(d[15:0]));
            default: dv = d;
        endcase
        xv = x * ((sc == 2'd0) ? 32'd1 : (sc == 2'd1) ? 32'd2 : 32'd4);
        case (m)
            3'd0: return dv;
            3'd1: return b;
            3'd2: return b + dv;
            3'd3: return xv + dv;
            3'd4: return b + xv + dv;
            default: return 32'd0;
        endcase
    endfunction

    // returns {mis, be}
    function automatic logic [4:0] f_lane(input logic [1:0] off, input int nb);
        logic [3:0] be = 4'b0;
        if (int'(off) + nb > 4) return 5'b1_0000;
        for (int k = 0; k < nb; k++) be[int'(off) + k] = 1'b1;
        return {1'b0, be};
    endfunction

    task automatic ea_case(input logic [2:0] m, input logic [31:0] b, input logic [31:0] x, input logic [1:0] sc,
                           input logic [31:0] d, input logic [1:0] dz, input logic [1:0] acc, input string req);
        logic [31:0] e;
        logic [4:0]  l;
        @(negedge clk);
        am_mode_i = m; am_base_i = b; am_index_i = x; am_scale_i = sc;
        am_disp_i = d; am_dsz_i = dz; am_acc_i = acc;
        #5;
        e = f_ea(m, b, x, sc, d, dz);
        l = f_lane(e[1:0], (acc == 2'd0) ? 1 : (acc == 2'd1) ? 2 : 4);
        chk(am_addr_o === e, req, am_addr_o, e);
        chk({am_mis_o, am_be_o} === l, "R4/R5 lanes", {27'd0, am_mis_o, am_be_o}, {27'd0, l});
    endtask

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_push(input bit four);
        logic [4:0] l;
        push_i = 1'b1; stk_sz4_i = four;
        tick();
        push_i = 1'b0;
        exp_sp = exp_sp - (four ? 32'd4 : 32'd2);
        l = f_lane(exp_sp[1:0], four ? 4 : 2);
        chk(sp_o === exp_sp, "R7 sp lowered", sp_o, exp_sp);
        chk(stk_wr_o && stk_addr_o === exp_sp, "R7 write at new sp", stk_addr_o, exp_sp);
        chk({stk_mis_o, stk_be_o} === l, "R11 push lanes", {27'd0, stk_mis_o, stk_be_o}, {27'd0, l});
        tick();
        chk(!stk_wr_o && !stk_busy_o, "R7 single write", {30'd0, stk_wr_o, stk_busy_o}, 32'd0);
    endtask

    task automatic do_pop(input bit four);
        logic [4:0] l;
        pop_i = 1'b1; stk_sz4_i = four;
        tick();
        pop_i = 1'b0;
        l = f_lane(exp_sp[1:0], four ? 4 : 2);
        chk(stk_rd_o && stk_addr_o === exp_sp && sp_o === exp_sp, "R8 read at old sp", stk_addr_o, exp_sp);
        chk({stk_mis_o, stk_be_o} === l, "R11 pop lanes", {27'd0, stk_mis_o, stk_be_o}, {27'd0, l});
        tick();
        exp_sp = exp_sp + (four ? 32'd4 : 32'd2);
        chk(sp_o === exp_sp && !stk_rd_o, "R8 sp raised", sp_o, exp_sp);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4217));
        tick(); tick();
        rst = 1'b0;
        exp_sp = 32'h0000_1000;
        // R6 reset state
        chk(sp_o === exp_sp && !stk_wr_o && !stk_rd_o && !stk_err_o && !stk_busy_o && stk_be_o === 4'b0,
            "R6 reset", sp_o, exp_sp);

        // directed address cases
        ea_case(3'd0, 32'h0, 32'h0, 2'd0, 32'h0000_1234, 2'd3, 2'd2, "R1 disp only");
        ea_case(3'd1, 32'h0000_8000, 32'h5, 2'd1, 32'h77, 2'd1, 2'd2, "R1 base only");
        ea_case(3'd2, 32'h0000_2000, 32'h0, 2'd0, 32'h0000_0080, 2'd1, 2'd2, "R3 disp8 negative");
        ea_case(3'd2, 32'h0001_0000, 32'h0, 2'd0, 32'hABCD_8000, 2'd2, 2'd2, "R3 disp16 negative");
        ea_case(3'd2, 32'hFFFF_FFFF, 32'h0, 2'd0, 32'h0000_0001, 2'd1, 2'd0, "R3 wrap");
        ea_case(3'd2, 32'h100, 32'h0, 2'd0, 32'hFFFF_FFFF, 2'd0, 2'd0, "R3 no disp");
        ea_case(3'd3, 32'h999, 32'h10, 2'd3, 32'h4, 2'd1, 2'd2, "R2 scale code 3");
        ea_case(3'd4, 32'h1000, 32'h3, 2'd1, 32'hFE, 2'd1, 2'd1, "R1 full form");
        ea_case(3'd6, 32'h1000, 32'h3, 2'd1, 32'h8, 2'd1, 2'd0, "R1 reserved mode");
        ea_case(3'd1, 32'h0000_0103, 32'h0, 2'd0, 32'h0, 2'd0, 2'd0, "R4 byte lane 3");
        ea_case(3'd1, 32'h0000_0103, 32'h0, 2'd0, 32'h0, 2'd0, 2'd1, "R5 half at lane 3");
        ea_case(3'd1, 32'h0000_0101, 32'h0, 2'd0, 32'h0, 2'd0, 2'd2, "R5 word at lane 1");
        ea_case(3'd1, 32'h0000_0102, 32'h0, 2'd0, 32'h0, 2'd0, 2'd1, "R4 half at lane 2");

        // random address cases
        for (int i = 0; i < 300; i++) begin
            ea_case(3'($urandom_range(0, 5)), $urandom, $urandom, 2'($urandom), $urandom,
                    2'($urandom), 2'($urandom), "R1/R2/R3 random");
        end

        // stack sequences
        do_push(1'b1);
        do_push(1'b0);
        do_push(1'b1);   // 4-byte push at lane 2: misaligned (R11)
        do_pop(1'b1);
        do_pop(1'b0);
        do_pop(1'b1);
        chk(sp_o === 32'h0000_1000, "R8 stack balanced", sp_o, 32'h0000_1000);

        // R9 conflict
        push_i = 1'b1; pop_i = 1'b1;
        tick();
        push_i = 1'b0; pop_i = 1'b0;
        chk(stk_err_o && !stk_wr_o && !stk_rd_o && sp_o === exp_sp, "R9 conflict", sp_o, exp_sp);
        tick();
        chk(!stk_err_o && sp_o === exp_sp, "R9 single pulse", {31'd0, stk_err_o}, 32'd0);

        // R10 requests while busy are ignored
        push_i = 1'b1; stk_sz4_i = 1'b1;
        tick();
        push_i = 1'b0; pop_i = 1'b1;
        exp_sp = exp_sp - 32'd4;
        chk(stk_busy_o && stk_wr_o, "R10 busy in write", {31'd0, stk_busy_o}, 32'd1);
        tick();
        pop_i = 1'b0;
        chk(!stk_rd_o && !stk_busy_o && sp_o === exp_sp, "R10 pop ignored", sp_o, exp_sp);
        tick();
        chk(!stk_rd_o && sp_o === exp_sp, "R10 no late pop", sp_o, exp_sp);

        // random stack traffic
        for (int i = 0; i < 40; i++) begin
            if ($urandom_range(0, 1) == 0) do_push(1'($urandom));
            else do_pop(1'($urandom));
        end

        // R6 reset mid-run
        rst = 1'b1;
        tick();
        rst = 1'b0;
        exp_sp = 32'h0000_1000;
        chk(sp_o === exp_sp && !stk_busy_o, "R6 reset reload", sp_o, exp_sp);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule